// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose producer and consumer run on unrelated clocks. The writer pushes words on its own clock, the reader pops them on a second clock, and four active-low flags report the fill level. Two of the flags are plain empty and full indications. The other two warn that the buffer is nearly drained or nearly filled. Their margins are programmable at run time to any word count.

Each margin lives in an 18-bit register split into a low and a high 9-bit half. The write side loads these halves through the normal data input while the load control is held low. The read side returns them through the normal data output in the same rotating order. After reset both margins hold parameter defaults, so the threshold flags work without any programming. Pointers cross between the clock domains in Gray code. Each flag is computed and registered in the domain that owns it: empty and nearly-empty in the read domain, full and nearly-full in the write domain.

Top module: `pflag_fifo`

## Requirements
- R1: While the reset is asserted and after it is released, with no activity, the outputs are empty_n=0, aempty_n=0, full_n=1, afull_n=1 and dout=0.
- R2: Words leave in the order they were accepted. A pop happens at a rising rclk edge where ld_n=1, rd_en_n=0 and empty_n=1. The popped word appears on dout right after that same edge.
- R3: A push happens at a rising wclk edge where ld_n=1, wr_en_n=0 and full_n=1. When DEPTH words are unread, full_n is low and further writes are dropped. The write pointer and the stored data stay unchanged.
- R4: A read attempt while empty_n=0 is ignored: the read pointer and dout hold. dout also holds at every rclk edge where rd_en_n=1.
- R5: empty_n is high only while at least one unread word exists. Once traffic stops, empty_n settles to (unread count > 0) within SYNC_STAGES+2 rclk edges.
- R6: With traffic stopped, aempty_n is low exactly when the unread count is less than or equal to n. Here n is the low log2(DEPTH) bits of the empty-margin register.
- R7: With traffic stopped, afull_n is low exactly when the unread count is greater than or equal to DEPTH − m. Here m is the low log2(DEPTH) bits of the full-margin register.
- R8: After reset the empty margin holds AE_INIT and the full margin holds AF_INIT.
- R9: At a rising wclk edge with ld_n=0 and wr_en_n=0, din is written into the next margin half. The order is empty-margin bits 8:0, empty-margin bits 17:9, full-margin bits 8:0, full-margin bits 17:9, then back to the start. Such an edge stores nothing in the FIFO.
- R10: At a rising rclk edge with ld_n=0 and rd_en_n=0, dout takes the next margin half, in the same four-step rotating order as R9. Such an edge pops nothing.
- R11: A reset restores the margin defaults and restarts both the load and the readback order at the first half. It also empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain in step with its clock |
| wr_en_n | input | 1 | Active-low write enable |
| ld_n | input | 1 | Active-low margin access select, shared by both sides |
| din | input | 9 | Write data or margin half to load |
| rd_en_n | input | 1 | Active-low read enable |
| dout | output | 9 | Registered read data or margin half |
| empty_n | output | 1 | Low when nothing is unread (read domain) |
| aempty_n | output | 1 | Low when the unread count is at or below the empty margin (read domain) |
| afull_n | output | 1 | Low when the unread count is at or above DEPTH minus the full margin (write domain) |
| full_n | output | 1 | Low when DEPTH words are unread (write domain) |

## Verification
The delicate case is a push and a pop landing together while the fill level sits on the empty or the full boundary. One side then acts on a pessimistic, delayed view of the other. The bench provokes this with a 5 ns write clock and a 7 ns read clock, whose rising edges align every 35 ns. Phases with uneven random enable duty drive the buffer repeatedly into full and into empty. Every read clock, dout is compared with a queue model, and every clock checks that an open empty or full flag never permits an underflow or an overflow. The flags are checked exactly at the threshold steps once traffic has stopped.

// File: rtl/pflag_fifo_pkg.sv
`timescale 1ns/1ps
package pflag_fifo_pkg;

  localparam int unsigned WORD_W = 9;
  localparam int unsigned OFS_W  = 2 * WORD_W;
  localparam int unsigned CODE_W = 16;

  // Rotating selector over the four margin halves; the order is part of
  // the load and readback protocol.
  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } ofs_sel_e;

  function automatic logic [CODE_W-1:0] bin_to_gray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CODE_W-1:0] gray_to_bin(input logic [CODE_W-1:0] g);
    logic [CODE_W-1:0] b;
    b[CODE_W-1] = g[CODE_W-1];
    for (int i = CODE_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/pflag_fifo_rst_sync.sv
`timescale 1ns/1ps
module pflag_fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/pflag_fifo_sync.sv
`timescale 1ns/1ps
module pflag_fifo_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[0] <= '0;
        else        pipe_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/pflag_fifo_mem.sv
`timescale 1ns/1ps
module pflag_fifo_mem
  import pflag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] cell_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];

endmodule

// File: rtl/pflag_fifo_wr_ctl.sv
`timescale 1ns/1ps
module pflag_fifo_wr_ctl
  import pflag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned AE_INIT = 7,
  parameter int unsigned AF_INIT = 7,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en_n,
  input  logic              ld_n,
  input  logic [WORD_W-1:0] din,
  input  logic [PW-1:0]     rgray_s,
  output logic              full_n,
  output logic              afull_n,
  output logic [PW-1:0]     wgray,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0]    wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0]    rbin_s, used_d, af_lim;
  logic             full_n_q, full_n_d, afull_n_q, afull_n_d;
  logic [OFS_W-1:0] ae_q, ae_d, af_q, af_d;
  ofs_sel_e         seq_q, seq_d;
  logic             push, load;

  assign load = ~ld_n & ~wr_en_n;
  assign push = ld_n & ~wr_en_n & full_n_q;

  // pointer and flag next state
  always_comb begin
    wbin_d = wbin_q;
    if (push) wbin_d = wbin_q + PW'(1);
    wgray_d   = PW'(bin_to_gray(CODE_W'(wbin_d)));
    rbin_s    = PW'(gray_to_bin(CODE_W'(rgray_s)));
    used_d    = wbin_d - rbin_s;
    af_lim    = DEPTH_P - PW'(af_q[AW-1:0]);
    full_n_d  = (used_d != DEPTH_P);
    afull_n_d = (used_d < af_lim);
  end

  // margin register file next state
  always_comb begin
    ae_d  = ae_q;
    af_d  = af_q;
    seq_d = seq_q;
    if (load) begin
      unique case (seq_q)
        SEL_AE_LO: ae_d[WORD_W-1:0]     = din;
        SEL_AE_HI: ae_d[OFS_W-1:WORD_W] = din;
        SEL_AF_LO: af_d[WORD_W-1:0]     = din;
        default:   af_d[OFS_W-1:WORD_W] = din;
      endcase
      seq_d = ofs_sel_e'(seq_q + 2'd1);
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
      ae_q      <= OFS_W'(AE_INIT);
      af_q      <= OFS_W'(AF_INIT);
      seq_q     <= SEL_AE_LO;
    end else begin
      wbin_q    <= wbin_d;
      wgray_q   <= wgray_d;
      full_n_q  <= full_n_d;
      afull_n_q <= afull_n_d;
      ae_q      <= ae_d;
      af_q      <= af_d;
      seq_q     <= seq_d;
    end
  end

  assign full_n    = full_n_q;
  assign afull_n   = afull_n_q;
  assign wgray     = wgray_q;
  assign mem_we    = push;
  assign mem_waddr = wbin_q[AW-1:0];
  assign ae_ofs    = ae_q;
  assign af_ofs    = af_q;

endmodule

// File: rtl/pflag_fifo_rd_ctl.sv
`timescale 1ns/1ps
module pflag_fifo_rd_ctl
  import pflag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en_n,
  input  logic              ld_n,
  input  logic [PW-1:0]     wgray_s,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic              empty_n,
  output logic              aempty_n,
  output logic [PW-1:0]     rgray,
  output logic [AW-1:0]     mem_raddr,
  output logic [WORD_W-1:0] dout
);

  logic [PW-1:0]     rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0]     wbin_s, avail_d, ae_lim;
  logic              empty_n_q, empty_n_d, aempty_n_q, aempty_n_d;
  logic [WORD_W-1:0] dout_q, dout_d, peek_word;
  ofs_sel_e          seq_q, seq_d;
  logic              pop, peek;

  assign pop  = ld_n & ~rd_en_n & empty_n_q;
  assign peek = ~ld_n & ~rd_en_n;

  always_comb begin
    rbin_d = rbin_q;
    if (pop) rbin_d = rbin_q + PW'(1);
    rgray_d    = PW'(bin_to_gray(CODE_W'(rbin_d)));
    wbin_s     = PW'(gray_to_bin(CODE_W'(wgray_s)));
    avail_d    = wbin_s - rbin_d;
    ae_lim     = PW'(ae_ofs[AW-1:0]);
    empty_n_d  = (avail_d != '0);
    aempty_n_d = (avail_d > ae_lim);
  end

  always_comb begin
    unique case (seq_q)
      SEL_AE_LO: peek_word = ae_ofs[WORD_W-1:0];
      SEL_AE_HI: peek_word = ae_ofs[OFS_W-1:WORD_W];
      SEL_AF_LO: peek_word = af_ofs[WORD_W-1:0];
      default:   peek_word = af_ofs[OFS_W-1:WORD_W];
    endcase
  end

  always_comb begin
    dout_d = dout_q;
    seq_d  = seq_q;
    if (pop) begin
      dout_d = mem_rdata;
    end else if (peek) begin
      dout_d = peek_word;
      seq_d  = ofs_sel_e'(seq_q + 2'd1);
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
      dout_q     <= '0;
      seq_q      <= SEL_AE_LO;
    end else begin
      rbin_q     <= rbin_d;
      rgray_q    <= rgray_d;
      empty_n_q  <= empty_n_d;
      aempty_n_q <= aempty_n_d;
      dout_q     <= dout_d;
      seq_q      <= seq_d;
    end
  end

  assign empty_n   = empty_n_q;
  assign aempty_n  = aempty_n_q;
  assign rgray     = rgray_q;
  assign mem_raddr = rbin_q[AW-1:0];
  assign dout      = dout_q;

endmodule

// File: rtl/pflag_fifo.sv
`timescale 1ns/1ps
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AE_INIT     = 7,
  parameter int unsigned AF_INIT     = 7
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic       wr_en_n,
  input  logic       ld_n,
  input  logic [8:0] din,
  input  logic       rd_en_n,
  output logic [8:0] dout,
  output logic       empty_n,
  output logic       aempty_n,
  output logic       afull_n,
  output logic       full_n
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wgray_w, rgray_r, wgray_s, rgray_s;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [WORD_W-1:0] mem_rdata;
  logic [OFS_W-1:0]  ae_ofs, af_ofs;

  pflag_fifo_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  pflag_fifo_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  pflag_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_w), .q(wgray_s)
  );

  pflag_fifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_r), .q(rgray_s)
  );

  pflag_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  pflag_fifo_wr_ctl #(.DEPTH(DEPTH), .AE_INIT(AE_INIT), .AF_INIT(AF_INIT)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en_n(wr_en_n), .ld_n(ld_n), .din(din),
    .rgray_s(rgray_s), .full_n(full_n), .afull_n(afull_n), .wgray(wgray_w),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  pflag_fifo_rd_ctl #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en_n(rd_en_n), .ld_n(ld_n),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .empty_n(empty_n), .aempty_n(aempty_n), .rgray(rgray_r),
    .mem_raddr(mem_raddr), .dout(dout)
  );

endmodule

// File: rtl/pflag_fifo_chk.sv
`timescale 1ns/1ps
module pflag_fifo_chk #(
  parameter int unsigned PW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          ld_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [8:0]    dout,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (ld_n && !wr_en_n && !full_n) |=> $stable(wgray));

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (ld_n && !rd_en_n && !empty_n) |=> $stable(rgray));

  assert_dout_hold_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_en_n |=> $stable(dout));

  assert_full_in_afull_R7: assert property (@(posedge wclk) disable iff (!wrst_n)
    !full_n |-> !afull_n);

  assert_empty_in_aempty_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
    !empty_n |-> !aempty_n);

  assert_load_no_push_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
    !ld_n |=> $stable(wgray));

  assert_peek_no_pop_R10: assert property (@(posedge rclk) disable iff (!rrst_n)
    !ld_n |=> $stable(rgray));

  assert_wgray_step_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

endmodule

bind pflag_fifo pflag_fifo_chk #(.PW(PW)) chk_i (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .ld_n(ld_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .dout(dout), .wgray(wgray_w), .rgray(rgray_r)
);

// File: tb/pflag_fifo_tb_top.sv
`timescale 1ns/1ps
module pflag_fifo_tb_top;

  localparam int unsigned DEPTH   = 64;
  localparam int unsigned AW      = 6;
  localparam int unsigned AE_INIT = 7;
  localparam int unsigned AF_INIT = 7;

  logic       wclk = 1'b0;
  logic       rclk = 1'b0;
  logic       rst_n, wr_en_n, rd_en_n, ld_n;
  logic [8:0] din, dout;
  logic       empty_n, aempty_n, afull_n, full_n;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  pflag_fifo #(.DEPTH(DEPTH), .AE_INIT(AE_INIT), .AF_INIT(AF_INIT)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .ld_n(ld_n),
    .din(din), .rd_en_n(rd_en_n), .dout(dout), .empty_n(empty_n),
    .aempty_n(aempty_n), .afull_n(afull_n), .full_n(full_n)
  );

  // reference model state
  int          q[$];
  logic [17:0] m_ae, m_af;
  int          m_wseq, m_rseq;
  logic [8:0]  exp_dout;
  logic [8:0]  wval;
  int          vec = 0;
  int          bad = 0;
  logic        run_chk = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_ae   = 18'(AE_INIT);
      m_af   = 18'(AF_INIT);
      m_wseq = 0;
    end else if (ld_n && !wr_en_n && full_n) begin
      if (q.size() < DEPTH) q.push_back(int'(din));
    end else if (!ld_n && !wr_en_n) begin
      case (m_wseq)
        0: m_ae[8:0]  = din;
        1: m_ae[17:9] = din;
        2: m_af[8:0]  = din;
        default: m_af[17:9] = din;
      endcase
      m_wseq = (m_wseq + 1) % 4;
    end
  end

  always @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      m_rseq   = 0;
      exp_dout = '0;
    end else if (ld_n && !rd_en_n && empty_n) begin
      if (q.size() == 0) begin
        bad++;
        vec++;
        $display("FAIL R4 pop while model empty actual=1 expected=0");
      end else begin
        exp_dout = 9'(q.pop_front());
      end
    end else if (!ld_n && !rd_en_n) begin
      case (m_rseq)
        0: exp_dout = m_ae[8:0];
        1: exp_dout = m_ae[17:9];
        2: exp_dout = m_af[8:0];
        default: exp_dout = m_af[17:9];
      endcase
      m_rseq = (m_rseq + 1) % 4;
    end
  end

  // every-clock comparisons
  always @(negedge rclk) begin
    if (rst_n && run_chk) begin
      chk("R2/R10 dout vs model", int'(dout), int'(exp_dout));
      if (empty_n) chk("R5 empty_n open implies data", int'(q.size() > 0), 1);
    end
  end

  always @(negedge wclk) begin
    if (rst_n && run_chk && full_n)
      chk("R3 full_n open implies room", int'(q.size() < DEPTH), 1);
  end

  task automatic settle();
    repeat (8) @(posedge wclk);
    repeat (8) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic flags(input string ctx);
    int s, n, m;
    s = q.size();
    n = int'(m_ae[AW-1:0]);
    m = int'(m_af[AW-1:0]);
    chk({"R5 empty_n ", ctx}, int'(empty_n), int'(s > 0));
    chk({"R3 full_n ", ctx}, int'(full_n), int'(s < DEPTH));
    chk({"R6 aempty_n ", ctx}, int'(aempty_n), int'(s > n));
    chk({"R7 afull_n ", ctx}, int'(afull_n), int'(s < int'(DEPTH) - m));
  endtask

  task automatic push_n(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge wclk);
      wr_en_n = 1'b0;
      din     = wval;
      wval    = wval + 9'd1;
    end
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic pop_n(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge rclk);
      rd_en_n = 1'b0;
    end
    @(negedge rclk);
    rd_en_n = 1'b1;
  endtask

  task automatic load_word(input logic [8:0] v);
    @(negedge wclk);
    wr_en_n = 1'b0;
    din     = v;
    @(negedge wclk);
    wr_en_n = 1'b1;
  endtask

  task automatic peek_chk(input string tag, input logic [8:0] e);
    @(negedge rclk);
    rd_en_n = 1'b0;
    @(negedge rclk);
    rd_en_n = 1'b1;
    chk(tag, int'(dout), int'(e));
  endtask

  task automatic set_ld(input logic v);
    @(negedge wclk);
    ld_n = v;
    repeat (2) @(negedge rclk);
  endtask

  task automatic mixed(input int cycles, input int wduty, input int rduty);
    fork
      for (int i = 0; i < cycles; i++) begin
        @(negedge wclk);
        wr_en_n = ($urandom_range(0, 99) >= wduty);
        din     = wval;
        wval    = wval + 9'd1;
      end
      for (int i = 0; i < cycles; i++) begin
        @(negedge rclk);
        rd_en_n = ($urandom_range(0, 99) >= rduty);
      end
    join
    @(negedge wclk);
    wr_en_n = 1'b1;
    @(negedge rclk);
    rd_en_n = 1'b1;
  endtask

  task automatic run_all();
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1;
    din = '0; wval = '0;
    repeat (4) @(posedge wclk);
    @(negedge wclk);
    rst_n   = 1'b1;
    run_chk = 1'b1;
    settle();
    // R1 reset state
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 aempty_n", int'(aempty_n), 0);
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 afull_n", int'(afull_n), 1);
    chk("R1 dout", int'(dout), 0);

    // R8 defaults seen through readback R10
    set_ld(1'b0);
    peek_chk("R8 ae low", 9'(AE_INIT));
    peek_chk("R8 ae high", 9'd0);
    peek_chk("R8 af low", 9'(AF_INIT));
    peek_chk("R8 af high", 9'd0);
    set_ld(1'b1);
    settle();
    flags("R10 after default readback");

    // R2 order, R6 above margin
    push_n(10);
    settle();
    flags("ten words");
    pop_n(10);
    pop_n(3);   // R4 reads while empty
    settle();
    flags("drained");
    chk("R4 dout held after empty reads", int'(dout), 9);

    // R3 overflow
    push_n(DEPTH + 3);
    settle();
    flags("overfilled");
    chk("R3 full_n at depth", int'(full_n), 0);

    // R7 boundary walk down from full
    for (int i = 0; i < 10; i++) begin
      pop_n(1);
      settle();
      flags("afull walk");
    end
    pop_n(q.size() + 2);
    settle();
    flags("drained again");

    // R6 boundary walk up from empty
    for (int i = 0; i < 10; i++) begin
      push_n(1);
      settle();
      flags("aempty walk");
    end
    pop_n(q.size() + 1);
    settle();

    // R9 load order with wrap, R10 readback order with wrap
    set_ld(1'b0);
    load_word(9'h114);
    load_word(9'h1A5);
    load_word(9'd12);
    load_word(9'h0C3);
    load_word(9'h116);
    peek_chk("R10 ae low", 9'h116);
    peek_chk("R10 ae high", 9'h1A5);
    peek_chk("R10 af low", 9'd12);
    peek_chk("R10 af high", 9'h0C3);
    peek_chk("R10 wrap to ae low", 9'h116);
    set_ld(1'b1);
    settle();
    chk("R9 load stored no word", int'(empty_n), 0);
    flags("after programming");

    // R6/R7 with programmed margins n=22 m=12
    for (int i = 0; i < 56; i++) begin
      push_n(1);
      settle();
      flags("programmed walk");
    end
    pop_n(q.size() + 1);
    settle();

    // concurrent traffic around full and empty
    mixed(1500, 85, 45);
    settle();
    flags("after fill-heavy mix");
    mixed(1500, 45, 85);
    settle();
    flags("after drain-heavy mix");

    // R11 reset mid-program
    push_n(5);
    set_ld(1'b0);
    load_word(9'h033);
    set_ld(1'b1);
    @(negedge wclk);
    rst_n = 1'b0;
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    rst_n = 1'b1;
    settle();
    flags("R11 after reset");
    chk("R11 dout cleared", int'(dout), 0);
    set_ld(1'b0);
    peek_chk("R11 ae low restored", 9'(AE_INIT));
    peek_chk("R11 ae high restored", 9'd0);
    peek_chk("R11 af low restored", 9'(AF_INIT));
    peek_chk("R11 af high restored", 9'd0);
    set_ld(1'b1);
    settle();
  endtask

  initial begin
    fork
      run_all();
      begin
        #1000000;
        bad++;
        vec++;
        $display("FAIL watchdog all requirements actual=running expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule